// File: doc/BRIEF.md
# Reset and Wake-up Cause Capture Unit

This unit sits beside a small processor core and records why the core last restarted or woke up. It receives single-cycle strobes for eight kinds of event (power-on, external reset pin, software reset instruction, watchdog expiry, trap conflict, illegal operation, clock failure and interrupt wake-up). It also sees the core's present power-saving mode and program counter. Each event updates a chosen subset of an eight-bit sticky flag register and leaves the remaining bits alone. In the same step it issues a one-cycle program counter load strobe together with the address at which execution continues.

Software may overwrite the whole flag register at any time. A flag therefore holds its last written value until an event changes that bit. When several strobes coincide, a fixed priority picks one cause. A software write that lands in the same cycle as an event is overridden only on the bits that event updates.

Flag bit positions: bit 0 power-on, bit 1 pin reset, bit 2 software reset, bit 3 watchdog, bit 4 trap conflict, bit 5 illegal operation, bit 6 idle, bit 7 sleep. The `pmode` encoding is 0 for run, 1 for idle and 2 for sleep. Value 3 is treated as run.

Top module: `rstcause_capture`

## Requirements
- R1: While reset is applied, and until the first event after it, `flags` reads 0x01 (only bit 0 set), `pc_load` is 0 and `pc_next` is 0.
- R2: A cycle with `wr_en` high and no event loads `wr_data` into `flags`. A cycle with neither a write nor an event leaves `flags` and `pc_next` unchanged and keeps `pc_load` low.
- R3: A power-on strobe sets bit 0, clears bits 1 to 7 and loads the program counter with the reset vector 0x000000.
- R4: A pin reset in run mode sets bit 1, clears bit 2 and leaves all other bits unchanged. The program counter target is 0x000000.
- R5: A pin reset in sleep sets bits 1 and 7 and clears bit 3. A pin reset in idle sets bits 1 and 6 and clears bit 7. Both target 0x000000, and all other bits are unchanged.
- R6: A software reset sets bit 2, clears bits 1 and 3, leaves the other bits unchanged and targets 0x000000.
- R7: A watchdog expiry in run mode sets bit 3, clears bit 2 and targets 0x000000.
- R8: A watchdog expiry in sleep or idle is a wake-up. It sets bit 3 and the flag of the mode being left (bit 7 or bit 6), changes no other bit, and targets `cur_pc` + 2, wrapping modulo 2^PC_W.
- R9: A trap conflict sets bit 4 and an illegal operation sets bit 5. Each leaves the other flag unchanged, both may set together, and the target is 0x000000.
- R10: A clock failure changes no flag and targets 0x000004.
- R11: An interrupt wake-up changes no flag and targets `irq_vector`.
- R12: Coinciding strobes are resolved in this order: power-on, pin, watchdog, trap or illegal operation, software reset, clock failure, interrupt wake-up.
- R13: When a write and an event fall in the same cycle, the bits the event updates take the event's values and every other bit takes `wr_data`.
- R14: Every event produces `pc_load` high for exactly the cycle after the edge that sampled it, with `pc_next` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_power_on | input | 1 | Power-on event strobe |
| ev_pin | input | 1 | External reset pin event strobe |
| ev_sw | input | 1 | Software reset instruction strobe |
| ev_wdog | input | 1 | Watchdog expiry strobe |
| ev_trap | input | 1 | Trap conflict strobe |
| ev_illegal | input | 1 | Illegal operation strobe |
| ev_clkfail | input | 1 | Clock failure strobe |
| ev_irq_wake | input | 1 | Interrupt wake-up strobe |
| pmode | input | 2 | Power mode: 0 run, 1 idle, 2 sleep |
| cur_pc | input | PC_W | Current program counter |
| irq_vector | input | PC_W | Vector of the enabled interrupt |
| wr_en | input | 1 | Software write enable for the flag register |
| wr_data | input | 8 | Software write data |
| flags | output | 8 | Sticky cause flags |
| pc_load | output | 1 | Program counter load strobe |
| pc_next | output | PC_W | Program counter value to load |

## Verification
Every result of the block is due one clock after the edge that samples its stimulus: the flag update, the load strobe and the target address all appear together. The exception is the internal reset release, which holds the unit idle for two further edges after `rst_n` rises. The bench drives a stimulus on a falling edge and updates its reference model for that same stimulus. At the next falling edge, one rising edge later, it compares all three outputs against the model. This keeps the bench exactly one register stage behind the inputs in every cycle, including cycles in which nothing happens.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;

  localparam int FLAG_W = 8;

  // Flag bit positions (software visible, fixed)
  localparam int F_POR   = 0;
  localparam int F_PIN   = 1;
  localparam int F_SW    = 2;
  localparam int F_WDOG  = 3;
  localparam int F_TRAP  = 4;
  localparam int F_ILL   = 5;
  localparam int F_IDLE  = 6;
  localparam int F_SLEEP = 7;

  localparam logic [FLAG_W-1:0] FLAGS_RST = 8'h01;

  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_RSVD  = 2'b11
  } pmode_e;

  // Cause classes in descending priority after CS_NONE
  typedef enum logic [2:0] {
    CS_NONE    = 3'd0,
    CS_POR     = 3'd1,
    CS_PIN     = 3'd2,
    CS_WDOG    = 3'd3,
    CS_FAULT   = 3'd4,
    CS_SW      = 3'd5,
    CS_CLKFAIL = 3'd6,
    CS_IRQ     = 3'd7
  } cause_e;

  localparam int N_CLASS = 7;

endpackage

// File: rtl/rstcause_rst_sync.sv
module rstcause_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rstcause_arbiter.sv
module rstcause_arbiter
  import rstcause_pkg::*;
(
  input  logic                ev_power_on,
  input  logic                ev_pin,
  input  logic                ev_wdog,
  input  logic                ev_trap,
  input  logic                ev_illegal,
  input  logic                ev_sw,
  input  logic                ev_clkfail,
  input  logic                ev_irq_wake,
  output cause_e              winner
);

  // index 0 is the highest priority class
  logic [N_CLASS-1:0] req;

  always_comb begin
    req = {ev_irq_wake, ev_clkfail, ev_sw, (ev_trap | ev_illegal),
           ev_wdog, ev_pin, ev_power_on};
  end

  always_comb begin
    winner = CS_NONE;
    for (int i = N_CLASS - 1; i >= 0; i--) begin
      if (req[i]) winner = cause_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/rstcause_flag_next.sv
module rstcause_flag_next
  import rstcause_pkg::*;
(
  input  cause_e              cause,
  input  logic [1:0]          pmode,
  input  logic                ev_trap,
  input  logic                ev_illegal,
  output logic [FLAG_W-1:0]   set_m,
  output logic [FLAG_W-1:0]   clr_m
);

  logic in_sleep;
  logic in_idle;

  always_comb begin
    in_sleep = (pmode == PM_SLEEP);
    in_idle  = (pmode == PM_IDLE);
  end

  always_comb begin
    set_m = '0;
    clr_m = '0;
    unique case (cause)
      CS_POR: begin
        set_m[F_POR] = 1'b1;
        clr_m        = ~FLAGS_RST;
      end
      CS_PIN: begin
        set_m[F_PIN] = 1'b1;
        if (in_sleep) begin
          set_m[F_SLEEP] = 1'b1;
          clr_m[F_WDOG]  = 1'b1;
        end else if (in_idle) begin
          set_m[F_IDLE]  = 1'b1;
          clr_m[F_SLEEP] = 1'b1;
        end else begin
          clr_m[F_SW]    = 1'b1;
        end
      end
      CS_WDOG: begin
        set_m[F_WDOG] = 1'b1;
        if (in_sleep)     set_m[F_SLEEP] = 1'b1;
        else if (in_idle) set_m[F_IDLE]  = 1'b1;
        else              clr_m[F_SW]    = 1'b1;
      end
      CS_FAULT: begin
        set_m[F_TRAP] = ev_trap;
        set_m[F_ILL]  = ev_illegal;
      end
      CS_SW: begin
        set_m[F_SW]   = 1'b1;
        clr_m[F_PIN]  = 1'b1;
        clr_m[F_WDOG] = 1'b1;
      end
      default: begin
        set_m = '0;
        clr_m = '0;
      end
    endcase
  end

endmodule

// File: rtl/rstcause_pc_sel.sv
module rstcause_pc_sel
  import rstcause_pkg::*;
#(
  parameter int              PC_W        = 24,
  parameter logic [PC_W-1:0] RESET_VEC   = '0,
  parameter logic [PC_W-1:0] CLKFAIL_VEC = PC_W'(4),
  parameter int              PC_STEP     = 2
) (
  input  cause_e              cause,
  input  logic [1:0]          pmode,
  input  logic [PC_W-1:0]     cur_pc,
  input  logic [PC_W-1:0]     irq_vector,
  output logic                load,
  output logic [PC_W-1:0]     target
);

  localparam logic [PC_W-1:0] STEP_L = PC_W'(PC_STEP);

  logic is_wake_mode;

  always_comb begin
    is_wake_mode = (pmode == PM_SLEEP) || (pmode == PM_IDLE);
  end

  always_comb begin
    load   = (cause != CS_NONE);
    target = RESET_VEC;
    unique case (cause)
      CS_WDOG:    target = is_wake_mode ? (cur_pc + STEP_L) : RESET_VEC;
      CS_CLKFAIL: target = CLKFAIL_VEC;
      CS_IRQ:     target = irq_vector;
      default:    target = RESET_VEC;
    endcase
  end

endmodule

// File: rtl/rstcause_capture.sv
module rstcause_capture
  import rstcause_pkg::*;
#(
  parameter int              PC_W        = 24,
  parameter logic [PC_W-1:0] RESET_VEC   = '0,
  parameter logic [PC_W-1:0] CLKFAIL_VEC = PC_W'(4),
  parameter int              PC_STEP     = 2,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_power_on,
  input  logic              ev_pin,
  input  logic              ev_sw,
  input  logic              ev_wdog,
  input  logic              ev_trap,
  input  logic              ev_illegal,
  input  logic              ev_clkfail,
  input  logic              ev_irq_wake,
  input  logic [1:0]        pmode,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   irq_vector,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        flags,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next
);

  localparam logic [PC_W-1:0] STEP_L = PC_W'(PC_STEP);

  logic                rst_sync_n;
  cause_e              cause;
  logic [FLAG_W-1:0]   set_m;
  logic [FLAG_W-1:0]   clr_m;
  logic                sel_load;
  logic [PC_W-1:0]     sel_target;

  logic [FLAG_W-1:0]   flag_q, flag_d;
  logic                flag_en;
  logic                load_q, load_d;
  logic [PC_W-1:0]     pc_q, pc_d;
  logic                pc_en;

  rstcause_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rstcause_arbiter u_arb (
    .ev_power_on (ev_power_on),
    .ev_pin      (ev_pin),
    .ev_wdog     (ev_wdog),
    .ev_trap     (ev_trap),
    .ev_illegal  (ev_illegal),
    .ev_sw       (ev_sw),
    .ev_clkfail  (ev_clkfail),
    .ev_irq_wake (ev_irq_wake),
    .winner      (cause)
  );

  rstcause_flag_next u_fnext (
    .cause      (cause),
    .pmode      (pmode),
    .ev_trap    (ev_trap),
    .ev_illegal (ev_illegal),
    .set_m      (set_m),
    .clr_m      (clr_m)
  );

  rstcause_pc_sel #(
    .PC_W        (PC_W),
    .RESET_VEC   (RESET_VEC),
    .CLKFAIL_VEC (CLKFAIL_VEC),
    .PC_STEP     (PC_STEP)
  ) u_pcsel (
    .cause      (cause),
    .pmode      (pmode),
    .cur_pc     (cur_pc),
    .irq_vector (irq_vector),
    .load       (sel_load),
    .target     (sel_target)
  );

  // Per-bit merge: event update wins over software write, write over hold
  for (genvar b = 0; b < FLAG_W; b++) begin : g_flag_bit
    always_comb begin
      if (set_m[b])      flag_d[b] = 1'b1;
      else if (clr_m[b]) flag_d[b] = 1'b0;
      else if (wr_en)    flag_d[b] = wr_data[b];
      else               flag_d[b] = flag_q[b];
    end
  end

  always_comb begin
    flag_en = wr_en | sel_load;
    load_d  = sel_load;
    pc_en   = sel_load;
    pc_d    = sel_target;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  flag_q <= FLAGS_RST;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) load_q <= 1'b0;
    else             load_q <= load_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= '0;
    else if (pc_en)  pc_q <= pc_d;
  end

  assign flags   = flag_q;
  assign pc_load = load_q;
  assign pc_next = pc_q;

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  logic any_ev;
  assign any_ev = ev_power_on | ev_pin | ev_sw | ev_wdog | ev_trap |
                  ev_illegal | ev_clkfail | ev_irq_wake;

  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!any_ev && !wr_en) |=> ($stable(flags) && !pc_load && $stable(pc_next)));

  assert_por_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_power_on |=> (flags == FLAGS_RST && pc_next == RESET_VEC));

  assert_pin_run_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_pin && !ev_power_on && pmode == PM_RUN) |=>
      (flags[F_PIN] && !flags[F_SW] && pc_next == RESET_VEC));

  assert_sw_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_sw && !ev_power_on && !ev_pin && !ev_wdog && !ev_trap && !ev_illegal) |=>
      (flags[F_SW] && !flags[F_PIN] && !flags[F_WDOG]));

  assert_wdog_wake_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_wdog && !ev_power_on && !ev_pin && pmode == PM_SLEEP) |=>
      (pc_next == $past(cur_pc) + STEP_L && flags[F_WDOG] && flags[F_SLEEP]));

  assert_clkfail_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_clkfail && !wr_en && !ev_power_on && !ev_pin && !ev_wdog && !ev_trap &&
     !ev_illegal && !ev_sw) |=> (pc_next == CLKFAIL_VEC && $stable(flags)));

  assert_load_pulse_R14: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_ev |=> pc_load);

endmodule

// File: tb/tb_rstcause_capture.sv
module tb_rstcause_capture;

  localparam int CLK_P = 10;
  localparam int PW    = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_power_on, ev_pin, ev_sw, ev_wdog, ev_trap, ev_illegal, ev_clkfail, ev_irq_wake;
  logic [1:0]    pmode;
  logic [PW-1:0] cur_pc, irq_vector;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic [7:0]    flags;
  logic          pc_load;
  logic [PW-1:0] pc_next;

  always #(CLK_P/2) clk = ~clk;

  rstcause_capture dut (
    .clk(clk), .rst_n(rst_n),
    .ev_power_on(ev_power_on), .ev_pin(ev_pin), .ev_sw(ev_sw), .ev_wdog(ev_wdog),
    .ev_trap(ev_trap), .ev_illegal(ev_illegal), .ev_clkfail(ev_clkfail),
    .ev_irq_wake(ev_irq_wake), .pmode(pmode), .cur_pc(cur_pc),
    .irq_vector(irq_vector), .wr_en(wr_en), .wr_data(wr_data),
    .flags(flags), .pc_load(pc_load), .pc_next(pc_next)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  logic [7:0]    m_flags;
  logic [PW-1:0] m_pc;
  logic          m_load;

  // evs bit order: 0 por, 1 pin, 2 wdog, 3 trap, 4 illegal, 5 sw, 6 clkfail, 7 irq
  task automatic drive(input logic [7:0] evs, input logic [1:0] pm,
                       input logic [PW-1:0] pc, input logic [PW-1:0] iv,
                       input logic we, input logic [7:0] wd);
    ev_power_on = evs[0]; ev_pin = evs[1]; ev_wdog = evs[2]; ev_trap = evs[3];
    ev_illegal  = evs[4]; ev_sw  = evs[5]; ev_clkfail = evs[6]; ev_irq_wake = evs[7];
    pmode = pm; cur_pc = pc; irq_vector = iv; wr_en = we; wr_data = wd;
  endtask

  task automatic compare(input string tag);
    n_checks++;
    if (flags !== m_flags || pc_load !== m_load || pc_next !== m_pc) begin
      n_fail++;
      $display("FAIL %s: flags=%h load=%b pc=%h expected flags=%h load=%b pc=%h",
               tag, flags, pc_load, pc_next, m_flags, m_load, m_pc);
    end
  endtask

  // one stimulus cycle: drive, model it, check one edge later
  task automatic step(input logic [7:0] evs, input logic [1:0] pm,
                      input logic [PW-1:0] pc, input logic [PW-1:0] iv,
                      input logic we, input logic [7:0] wd, input string tag_in);
    logic [7:0] nf;
    logic [PW-1:0] np;
    logic nl;
    string tag;
    drive(evs, pm, pc, iv, we, wd);
    nf = we ? wd : m_flags;
    np = m_pc;
    nl = 1'b1;
    tag = tag_in;
    if (evs[0]) begin
      nf = 8'h01; np = '0; if (tag == "") tag = "R3";
    end else if (evs[1]) begin
      nf[1] = 1'b1; np = '0;
      if (pm == 2'd2)      begin nf[7] = 1'b1; nf[3] = 1'b0; if (tag == "") tag = "R5"; end
      else if (pm == 2'd1) begin nf[6] = 1'b1; nf[7] = 1'b0; if (tag == "") tag = "R5"; end
      else                 begin nf[2] = 1'b0;               if (tag == "") tag = "R4"; end
    end else if (evs[2]) begin
      nf[3] = 1'b1;
      if (pm == 2'd2)      begin nf[7] = 1'b1; np = pc + 2; if (tag == "") tag = "R8"; end
      else if (pm == 2'd1) begin nf[6] = 1'b1; np = pc + 2; if (tag == "") tag = "R8"; end
      else                 begin nf[2] = 1'b0; np = '0;     if (tag == "") tag = "R7"; end
    end else if (evs[3] || evs[4]) begin
      if (evs[3]) nf[4] = 1'b1;
      if (evs[4]) nf[5] = 1'b1;
      np = '0; if (tag == "") tag = "R9";
    end else if (evs[5]) begin
      nf[2] = 1'b1; nf[1] = 1'b0; nf[3] = 1'b0; np = '0; if (tag == "") tag = "R6";
    end else if (evs[6]) begin
      np = 24'h000004; if (tag == "") tag = "R10";
    end else if (evs[7]) begin
      np = iv; if (tag == "") tag = "R11";
    end else begin
      nl = 1'b0; if (tag == "") tag = "R2";
    end
    @(negedge clk);
    m_flags = nf; m_pc = np; m_load = nl;
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(8'h00, 2'd0, '0, '0, 1'b0, 8'h00);
    m_flags = 8'h01; m_pc = '0; m_load = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");                               // R1 during reset
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(8'h00, 2'd0, '0, '0, 1'b0, 8'h00, "R1");

    step(8'h00, 2'd0, '0, '0, 1'b1, 8'hFE, "R2");          // R2 write all but bit0
    step(8'h00, 2'd0, '0, '0, 1'b0, 8'h00, "R2");          // R2 hold
    step(8'h01, 2'd0, 24'h123, '0, 1'b0, 8'h00, "R3");     // R3
    step(8'h00, 2'd0, '0, '0, 1'b1, 8'h04, "R2");
    step(8'h02, 2'd0, 24'h40, '0, 1'b0, 8'h00, "R4");      // R4 pin in run
    step(8'h00, 2'd0, '0, '0, 1'b1, 8'h08, "R2");
    step(8'h02, 2'd2, 24'h40, '0, 1'b0, 8'h00, "R5");      // R5 pin in sleep
    step(8'h02, 2'd1, 24'h40, '0, 1'b0, 8'h00, "R5");      // R5 pin in idle
    step(8'h00, 2'd0, '0, '0, 1'b1, 8'h0A, "R2");
    step(8'h20, 2'd0, 24'h80, '0, 1'b0, 8'h00, "R6");      // R6
    step(8'h04, 2'd0, 24'h80, '0, 1'b0, 8'h00, "R7");      // R7 watchdog run
    step(8'h04, 2'd2, 24'h000100, '0, 1'b0, 8'h00, "R8");  // R8 sleep wake
    step(8'h04, 2'd1, 24'hFFFFFF, '0, 1'b0, 8'h00, "R8");  // R8 idle wake, wraps
    step(8'h00, 2'd0, '0, '0, 1'b1, 8'h20, "R2");
    step(8'h08, 2'd0, '0, '0, 1'b0, 8'h00, "R9");          // R9 trap keeps illegal flag
    step(8'h00, 2'd0, '0, '0, 1'b1, 8'h00, "R2");
    step(8'h18, 2'd0, '0, '0, 1'b0, 8'h00, "R9");          // R9 both together
    step(8'h40, 2'd0, 24'h55, '0, 1'b0, 8'h00, "R10");     // R10
    step(8'h80, 2'd2, 24'h55, 24'h000A20, 1'b0, 8'h00, "R11"); // R11
    step(8'h00, 2'd0, '0, '0, 1'b0, 8'h00, "R14");         // R14 strobe drops
    step(8'hFE, 2'd0, 24'h10, 24'h30, 1'b0, 8'h00, "R12"); // R12 pin wins
    step(8'hFC, 2'd2, 24'h10, 24'h30, 1'b0, 8'h00, "R12"); // R12 watchdog wins
    step(8'hE0, 2'd0, 24'h10, 24'h30, 1'b0, 8'h00, "R12"); // R12 sw wins
    step(8'hC0, 2'd0, 24'h10, 24'h30, 1'b0, 8'h00, "R12"); // R12 clkfail wins
    step(8'h20, 2'd0, '0, '0, 1'b1, 8'hFF, "R13");         // R13 write vs sw reset
    step(8'h02, 2'd1, '0, '0, 1'b1, 8'h80, "R13");         // R13 write vs pin idle
    step(8'h40, 2'd0, '0, '0, 1'b1, 8'h3C, "R13");         // R13 no-flag event

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] evs;
      for (int b = 0; b < 8; b++) evs[b] = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 3) == 0) evs[0] = 1'b0;
      step(evs, 2'($urandom_range(0, 3)), PW'($urandom), PW'($urandom),
           ($urandom_range(0, 5) == 0), 8'($urandom),
           ($countones(evs) > 1) ? "R12" : "");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule